// File: doc/BRIEF.md
# Programmable Slot Arbiter for a Shared Memory Hub

This block decides, once per clock, which of sixteen processor cores owns the next access slot of a shared memory hub. The decision comes from a 64-entry schedule table. Each entry names an owner core and a backup core. The backup core takes the slot whenever the owner is not asking for it. The arbiter steps through the table one entry per clock. An entry can carry a restart flag that sends the walk back to entry 0, so a schedule may be shorter than the full table.

Any core may rewrite a table entry through a single write port. Each write replaces a whole entry in one clock, so the walk never reads a half-written entry. Core request flags pass through one register stage before they are compared against the table. The grant is registered again on the output, which keeps the table lookup and the request check off the critical timing path. The grant is given as a core index and as a one-hot vector, together with a valid flag.

Top module: `hub_slot_arbiter`

## Requirements
- R1: While reset is asserted and after reset, before the first clock edge, `grant_valid_o` is 0, `grant_oh_o` is 0 and `grant_id_o` is 0. Reset loads entry i with restart flag clear and with owner = backup = i mod 16, which gives plain round robin.
- R2: Table entry bit layout: bit 8 is the restart flag, bits 7:4 are the owner core id, and bits 3:0 are the backup core id.
- R3: When the owner core of the current entry has its registered request set, the grant goes to the owner.
- R4: When the owner's registered request is clear and the backup core's registered request is set, the grant goes to the backup core.
- R5: When neither the owner nor the backup is requesting, `grant_valid_o` is 0, `grant_oh_o` is 0 and `grant_id_o` is 0 for that slot.
- R6: When the current entry has the restart flag set, the next slot reads entry 0.
- R7: When the walk reaches entry 63 and the restart flag is clear, the next slot reads entry 0. Otherwise the index increases by one per clock.
- R8: A write with `tbl_we_i` high replaces all 9 bits of entry `tbl_addr_i` at the clock edge. If the write targets the entry being read in that cycle, the slot in that cycle still uses the old contents, and the new contents apply from the next pass.
- R9: `req_i` is registered once before arbitration. The grant for the slot that reads entry k in cycle n uses the `req_i` value sampled at the edge that opens cycle n, and it appears on the outputs after the edge that closes cycle n.
- R10: When `grant_valid_o` is 1, `grant_oh_o` has exactly one bit set, at position `grant_id_o`.
- R11: An entry whose owner and backup fields are equal is a dedicated slot. It is granted only when that core requests, and it is otherwise left unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Per-core hub request flags |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 6 | Table entry to write |
| tbl_data_i | input | 9 | New entry contents {restart, owner, backup} |
| grant_valid_o | output | 1 | A core owns the current slot |
| grant_id_o | output | 4 | Index of the granted core |
| grant_oh_o | output | 16 | One-hot form of the granted core |

## Verification
Requests are applied in several patterns, each of which separates one arbitration outcome from the others:
- With every core requesting on the reset table, the grant walks 0..15 repeatedly, which shows the reset contents and the wrap after entry 63.
- With a table filled with one owner/backup pair, raising only the backup, then both cores, then a third core, separates owner grant, backup grant and no grant.
- A short schedule ended by a restart flag, and a dedicated-slot schedule with that core idle, isolate R6 and R11.
- Requests changing every cycle expose any error in the two-stage latency.
- Random table writes issued alongside the walk catch a lookup that sees the new data too early.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int unsigned NUM_CORES = 16;
  localparam int unsigned CORE_W    = $clog2(NUM_CORES);
  localparam int unsigned TBL_DEPTH = 64;
  localparam int unsigned IDX_W     = $clog2(TBL_DEPTH);
  localparam int unsigned ENTRY_W   = 1 + 2 * CORE_W;

  typedef struct packed {
    logic              restart;
    logic [CORE_W-1:0] owner;
    logic [CORE_W-1:0] backup;
  } slot_entry_t;
endpackage

// File: rtl/slot_table.sv
module slot_table
  import slot_arb_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [IDX_W-1:0]   waddr_i,
  input  slot_entry_t        wdata_i,
  input  logic [IDX_W-1:0]   raddr_i,
  output slot_entry_t        rdata_o
);
  slot_entry_t tbl_q [TBL_DEPTH];

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_ent
    localparam logic [CORE_W-1:0] DefCore = CORE_W'(g % NUM_CORES);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tbl_q[g] <= '{restart: 1'b0, owner: DefCore, backup: DefCore};
      end else if (we_i && waddr_i == IDX_W'(g)) begin
        tbl_q[g] <= wdata_i;  // whole entry in one edge
      end
    end
  end

  // read sees pre-write contents in the write cycle
  assign rdata_o = tbl_q[raddr_i];

  assert_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> tbl_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/slot_index.sv
module slot_index
  import slot_arb_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(TBL_DEPTH - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          idx_q <= '0;
    else if (restart_i || idx_q == LastIdx) idx_q <= '0;
    else                                  idx_q <= idx_q + 1'b1;
  end

  assign idx_o = idx_q;

  assert_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> idx_q == '0);
  assert_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == LastIdx) |=> idx_q == '0);
  assert_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart_i && idx_q != LastIdx) |=> idx_q == $past(idx_q) + 1'b1);
endmodule

// File: rtl/slot_pick.sv
module slot_pick
  import slot_arb_pkg::*;
(
  input  slot_entry_t           entry_i,
  input  logic [NUM_CORES-1:0]  req_i,
  output logic                  valid_o,
  output logic [CORE_W-1:0]     id_o
);
  logic own_req, bak_req;

  always_comb begin
    own_req = req_i[entry_i.owner];
    bak_req = req_i[entry_i.backup];
    valid_o = own_req | bak_req;
    if (own_req)      id_o = entry_i.owner;
    else if (bak_req) id_o = entry_i.backup;
    else              id_o = '0;
  end
endmodule

// File: rtl/hub_slot_arbiter.sv
module hub_slot_arbiter
  import slot_arb_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] req_i,
  input  logic                 tbl_we_i,
  input  logic [IDX_W-1:0]     tbl_addr_i,
  input  logic [ENTRY_W-1:0]   tbl_data_i,
  output logic                 grant_valid_o,
  output logic [CORE_W-1:0]    grant_id_o,
  output logic [NUM_CORES-1:0] grant_oh_o
);
  logic [NUM_CORES-1:0] req_q;
  logic [IDX_W-1:0]     idx;
  slot_entry_t          cur_entry;
  logic                 pick_valid;
  logic [CORE_W-1:0]    pick_id;
  logic                 valid_q;
  logic [CORE_W-1:0]    id_q;

  // stage 1: request flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_i;
  end

  slot_index i_index (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (cur_entry.restart),
    .idx_o     (idx)
  );

  slot_table i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wdata_i (slot_entry_t'(tbl_data_i)),
    .raddr_i (idx),
    .rdata_o (cur_entry)
  );

  slot_pick i_pick (
    .entry_i (cur_entry),
    .req_i   (req_q),
    .valid_o (pick_valid),
    .id_o    (pick_id)
  );

  // stage 2: registered grant
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      id_q    <= '0;
    end else begin
      valid_q <= pick_valid;
      id_q    <= pick_id;
    end
  end

  assign grant_valid_o = valid_q;
  assign grant_id_o    = id_q;

  for (genvar g = 0; g < NUM_CORES; g++) begin : g_oh
    assign grant_oh_o[g] = valid_q && (id_q == CORE_W'(g));
  end

  assert_owner_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q[cur_entry.owner] |=> grant_valid_o && grant_id_o == $past(cur_entry.owner));
  assert_backup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q[cur_entry.owner] && req_q[cur_entry.backup])
      |=> grant_valid_o && grant_id_o == $past(cur_entry.backup));
  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q[cur_entry.owner] && !req_q[cur_entry.backup])
      |=> !grant_valid_o && grant_oh_o == '0 && grant_id_o == '0);
  assert_onehot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> $onehot(grant_oh_o) && grant_oh_o[grant_id_o]);
endmodule

// File: tb/test_hub_slot_arbiter.sv
module test_hub_slot_arbiter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] req_i = '0;
  logic        tbl_we_i = 1'b0;
  logic [5:0]  tbl_addr_i = '0;
  logic [8:0]  tbl_data_i = '0;
  logic        grant_valid_o;
  logic [3:0]  grant_id_o;
  logic [15:0] grant_oh_o;

  int    total = 0;
  int    bad = 0;
  string tag = "R1";

  always #10 clk_i = ~clk_i;  // 50 MHz

  hub_slot_arbiter i_hub_slot_arbiter (
    .clk_i, .rst_ni, .req_i, .tbl_we_i, .tbl_addr_i, .tbl_data_i,
    .grant_valid_o, .grant_id_o, .grant_oh_o
  );

  // requirement model: table, walk, one request stage, one grant stage
  logic [8:0]  m_tbl [64];
  logic [5:0]  m_idx;
  logic [15:0] m_req;
  logic        exp_v;
  logic [3:0]  exp_id;
  logic [8:0]  m_e;
  assign m_e = m_tbl[m_idx];

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 64; i++) m_tbl[i] <= {1'b0, 4'(i), 4'(i)};
      m_idx <= '0; m_req <= '0; exp_v <= 1'b0; exp_id <= '0;
    end else begin
      if (m_req[m_e[7:4]])      begin exp_v <= 1'b1; exp_id <= m_e[7:4]; end
      else if (m_req[m_e[3:0]]) begin exp_v <= 1'b1; exp_id <= m_e[3:0]; end
      else                      begin exp_v <= 1'b0; exp_id <= '0; end
      m_idx <= m_e[8] ? 6'd0 : m_idx + 6'd1;
      m_req <= req_i;
      if (tbl_we_i) m_tbl[tbl_addr_i] <= tbl_data_i;
    end
  end

  task automatic check_out(input logic v, input logic [3:0] id);
    logic [15:0] oh;
    oh = v ? (16'h1 << id) : 16'h0;
    total++;
    if (grant_valid_o !== v || grant_id_o !== id || grant_oh_o !== oh) begin
      bad++;
      $display("FAIL %s: got v=%0b id=%0d oh=%h, want v=%0b id=%0d oh=%h",
               tag, grant_valid_o, grant_id_o, grant_oh_o, v, id, oh);
    end
  endtask

  // mode 0 hold, 1 random requests, 2 random requests and writes
  task automatic run(input int n, input int mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk_i);
      check_out(exp_v, exp_id);
      tbl_we_i = 1'b0;
      if (mode >= 1) req_i = 16'($urandom);
      if (mode == 2 && ($urandom % 2) == 0) begin
        tbl_we_i   = 1'b1;
        tbl_addr_i = 6'($urandom % 8);
        tbl_data_i = {1'b0, 8'($urandom)};
        if (tbl_addr_i == 6'd7) tbl_data_i[8] = 1'b1;
      end
    end
    @(negedge clk_i);
    tbl_we_i = 1'b0;
  endtask

  task automatic write_entry(input logic [5:0] a, input logic r,
                             input logic [3:0] own, input logic [3:0] bak);
    tbl_we_i = 1'b1; tbl_addr_i = a; tbl_data_i = {r, own, bak};  // R2 layout
    @(negedge clk_i);
    check_out(exp_v, exp_id);
    tbl_we_i = 1'b0;
  endtask

  task automatic t_reset;
    tag = "R1";
    rst_ni = 1'b0; req_i = '0;
    #5;
    check_out(1'b0, 4'd0);
    @(negedge clk_i);
    check_out(1'b0, 4'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_round_robin;  // R1 contents, R3, R7 wrap
    tag = "R7"; req_i = 16'hFFFF;
    run(140, 0);
  endtask

  task automatic t_backup;  // R2, R4, R3, R5
    tag = "R2";
    for (int i = 0; i < 64; i++) write_entry(6'(i), 1'b0, 4'd2, 4'd9);
    tag = "R4"; req_i = 16'h0200; run(20, 0);
    tag = "R3"; req_i = 16'h0204; run(20, 0);
    tag = "R5"; req_i = 16'h0020; run(20, 0);
  endtask

  task automatic t_restart;  // R6
    tag = "R6"; req_i = '0;
    for (int i = 0; i < 4; i++) write_entry(6'(i), (i == 3), 4'(i + 4), 4'(i + 4));
    req_i = 16'hFFFF;
    run(40, 0);
  endtask

  task automatic t_dedicated;  // R11
    tag = "R11";
    for (int i = 0; i < 4; i++) write_entry(6'(i), (i == 3), 4'd7, 4'd7);
    req_i = 16'hFF7F; run(16, 0);
    req_i = 16'h0080; run(16, 0);
  endtask

  task automatic t_latency;  // R9, R10
    tag = "R9";
    for (int i = 0; i < 8; i++) write_entry(6'(i), (i == 7), 4'(i), 4'(15 - i));
    run(200, 1);
    tag = "R10";
    run(100, 1);
  endtask

  task automatic t_live_write;  // R8
    tag = "R8";
    run(400, 2);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_round_robin();
        t_backup();
        t_restart();
        t_dedicated();
        t_latency();
        t_live_write();
      end
      begin
        repeat (20000) @(posedge clk_i);
        total++; bad++;
        $display("FAIL watchdog: got timeout, want completion");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule